// File: doc/BRIEF.md
# Asynchronous NOR Flash Timing Sequencer

This block drives an asynchronous NOR flash array from a simple host request port. It generates the active-low chip selects, output enable and write enable, the word address and the write data with its drive enable. It also captures read data. The address space is split into four regions, chosen by the top two address bits. Each region owns a 16-bit timing word, so read-optimised and write-optimised regions can share one flash part.

A timing word selects one of two read styles. A single-word access uses the full first-access delay. A burst-of-four page read steps through an aligned page: the first word waits the first-access delay and the other three wait the shorter page delay. The page-delay field also sets the width of the write-enable low pulse. A field for recovery time inserts dead cycles after each write.

A refresh request from an external memory controller can claim the bus. The grant is given only when the sequencer is idle or between two words of a burst, and it releases every chip select. A burst that resumes after a refresh restarts its timing with the first-access delay. All delays count cycles of `clk`, which runs at the memory clock rate.

Top module: `nor_timing_seq`

## Requirements
- R1: After reset, every chip select, the output enable and the write enable are high, and `done` and `refGnt` are low. Every region loads the slowest non-burst timing word 16'hFFF8, so a read then holds chip select low for 32 cycles.
- R2: `cfgData` written with `cfgIdx`=0 sets region 0 from bits 15:0 and region 1 from bits 31:16. With `cfgIdx`=1 it sets regions 2 and 3 the same way. The region of a request is `reqAddr[25:24]`, and region n drives `memCsN[n]`.
- R3: The timing word fields are: bits 1:0 burst mode, bit 2 bus width, bits 7:3 first delay F, bits 12:8 page delay P, bits 15:13 recovery C. The first word of a read holds the region's chip select and the output enable low for F+1 cycles. Data is captured at the edge that ends this window.
- R4: Burst mode 2 or 3 reads four words of the aligned page in order 0,1,2,3. The chip select and output enable stay low across the four words, and words 1 to 3 last P+1 cycles each.
- R5: Burst mode 0 or 1 reads one word at the unchanged request address, using F+1 cycles.
- R6: Bus-width bit 0 steps address bits 3:2 and returns all 32 data bits. Bus-width bit 1 steps address bits 2:1 and returns `memDin[15:0]` zero-extended.
- R7: For a write, the chip select falls one cycle before the write enable. The write enable stays low for P+1 cycles. The chip select, address and write data with `memDoe` high are then held for one more cycle. The output enable stays high.
- R8: After a write, the chip selects stay high for 2*C+1 cycles. A request sampled during that time is dropped, and one sampled in the next cycle is accepted.
- R9: A refresh request during a word does not release the chip select. If it is high at the edge that ends a non-final burst word, all chip selects and the output enable go high and `refGnt` is high until the request is seen low.
- R10: After a refresh grant inside a burst, the next word uses F+1 cycles, not P+1.
- R11: While idle, a refresh request takes priority. It is granted in the next cycle, and a host request sampled at the same edge is dropped.
- R12: A host request sampled while an access is in progress is dropped.
- R13: `done` is high for one cycle per completed word, in the cycle after the read window ends, with `rdata` valid. For a write it is high in the first recovery cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Timing register write strobe |
| cfgIdx | input | 1 | Timing register select (region pair) |
| cfgData | input | 32 | Two timing words, odd region in upper half |
| req | input | 1 | Host request, one-cycle pulse while idle |
| reqWe | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 26 | Byte address; top two bits pick the region |
| reqWdata | input | 32 | Write data |
| rdata | output | 32 | Captured read data |
| done | output | 1 | One pulse per completed word |
| refReq | input | 1 | Refresh request from memory controller |
| refGnt | output | 1 | Bus released for refresh |
| memCsN | output | 4 | Active-low chip selects, one per region |
| memOeN | output | 1 | Active-low output enable |
| memWeN | output | 1 | Active-low write enable |
| memAddr | output | 26 | Flash address |
| memDout | output | 32 | Flash write data |
| memDoe | output | 1 | Write data drive enable |
| memDin | input | 32 | Flash read data |

## Verification
A read's first `done` is due F+2 cycles after the edge that samples `req`, and each later burst word adds P+1 cycles, or F+1 after a refresh. For a write, the write enable falls in cycle 2 and `done` is due in cycle P+4. The bench numbers cycles from the accepting edge and records every output in the middle of each cycle. It then compares the recorded cycle indices with these formulas, computed from the programmed fields. Refresh and stray requests are applied at chosen cycle numbers, which puts them inside a word, at a word boundary, or exactly at the end of write recovery.

// File: rtl/fts_pkg.sv
package fts_pkg;

  // Per-region timing word; field positions are decoded by the sequencer
  typedef struct packed {
    logic [2:0] recov;     // 15:13 write recovery, 2*n+1 cycles
    logic [4:0] pageDly;   // 12:8  page access / write low, n+1 cycles
    logic [4:0] firstDly;  // 7:3   first access, n+1 cycles
    logic       halfBus;   // 2     1 = 16-bit data bus
    logic [1:0] burstMode; // 1:0   bit 1 set = burst of four
  } tmWord_t;

  localparam int TM_W = 16;
  localparam logic [TM_W-1:0] TM_RESET = 16'hFFF8;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_WSET, S_WLOW, S_WHOLD, S_WREC, S_REF
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic burst;
    logic half;
    logic step;
    logic capture;
    logic drive;
  } strobe_t;

endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
#(
  parameter int NUM_REGIONS = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWe,
  input  logic [((NUM_REGIONS/2 > 1) ? $clog2(NUM_REGIONS/2) : 1)-1:0] cfgIdx,
  input  logic [2*TM_W-1:0]           cfgData,
  input  logic                        req,
  input  logic                        reqWe,
  input  logic [$clog2(NUM_REGIONS)-1:0] reqRegion,
  input  logic                        refReq,
  output strobe_t                     strb,
  output logic [NUM_REGIONS-1:0]      memCsN,
  output logic                        memOeN,
  output logic                        memWeN,
  output logic                        done,
  output logic                        refGnt
);

  localparam int REG_CNT = NUM_REGIONS / 2;
  localparam int IDX_W   = (REG_CNT > 1) ? $clog2(REG_CNT) : 1;
  localparam int RSEL_W  = $clog2(NUM_REGIONS);
  localparam int CNT_W   = 5;

  logic [2*TM_W-1:0] cfgReg [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 cfgReg[g] <= {TM_RESET, TM_RESET};
      else if (cfgWe && cfgIdx == IDX_W'(g))     cfgReg[g] <= cfgData;
    end
  end

  logic [2*TM_W-1:0] pairSel;
  tmWord_t           tmSel;
  assign pairSel = cfgReg[reqRegion[RSEL_W-1:1]];
  assign tmSel   = tmWord_t'(reqRegion[0] ? pairSel[2*TM_W-1:TM_W] : pairSel[TM_W-1:0]);

  seqState_t          state;
  logic [CNT_W-1:0]   cnt;
  logic [1:0]         wordsLeft;
  logic [RSEL_W-1:0]  regionQ;
  logic [4:0]         firstQ, pageQ;
  logic [2:0]         recovQ;
  logic               resume, doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; cnt <= '0; wordsLeft <= '0; regionQ <= '0;
      firstQ <= '1; pageQ <= '1; recovQ <= '1; resume <= 1'b0; doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        S_IDLE: begin
          if (refReq) begin
            state <= S_REF; resume <= 1'b0;
          end else if (req) begin
            regionQ <= reqRegion;
            firstQ  <= tmSel.firstDly;
            pageQ   <= tmSel.pageDly;
            recovQ  <= tmSel.recov;
            if (reqWe) state <= S_WSET;
            else begin
              state     <= S_READ;
              cnt       <= tmSel.firstDly;
              wordsLeft <= tmSel.burstMode[1] ? 2'd3 : 2'd0;
            end
          end
        end
        S_READ: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            doneQ <= 1'b1;
            if (wordsLeft == 2'd0) state <= S_IDLE;
            else begin
              wordsLeft <= wordsLeft - 1'b1;
              if (refReq) begin state <= S_REF; resume <= 1'b1; end
              else cnt <= pageQ;
            end
          end
        end
        S_REF: begin
          if (!refReq) begin
            if (resume) begin state <= S_READ; cnt <= firstQ; end
            else state <= S_IDLE;
          end
        end
        S_WSET:  begin state <= S_WLOW; cnt <= pageQ; end
        S_WLOW:  if (cnt != '0) cnt <= cnt - 1'b1; else state <= S_WHOLD;
        S_WHOLD: begin doneQ <= 1'b1; state <= S_WREC; cnt <= CNT_W'({recovQ, 1'b0}); end
        S_WREC:  if (cnt != '0) cnt <= cnt - 1'b1; else state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic csOn;
  always_comb begin
    csOn         = state inside {S_READ, S_WSET, S_WLOW, S_WHOLD};
    strb.load    = (state == S_IDLE) && !refReq && req;
    strb.burst   = tmSel.burstMode[1] && !reqWe;
    strb.half    = tmSel.halfBus;
    strb.capture = (state == S_READ) && (cnt == '0);
    strb.step    = strb.capture && (wordsLeft != 2'd0);
    strb.drive   = state inside {S_WSET, S_WLOW, S_WHOLD};
    memCsN       = csOn ? ~(NUM_REGIONS'(1) << regionQ) : '1;
    memOeN       = (state != S_READ);
    memWeN       = (state != S_WLOW);
    done         = doneQ;
    refGnt       = (state == S_REF);
  end

  // R7
  we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memCsN != '1));
  // R7
  cs_before_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> $past(memCsN != '1));
  // R7
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    memOeN || memWeN);
  // R9
  ref_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    refGnt |-> (memCsN == '1 && memOeN && memWeN));

endmodule

// File: rtl/fts_path.sv
module fts_path
  import fts_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoe,
  output logic [DATA_W-1:0] rdata
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic [1:0]        idx;
  logic              halfQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; wdataQ <= '0; rdataQ <= '0; idx <= '0; halfQ <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        halfQ  <= strb.half;
        idx    <= strb.burst ? 2'd0 : (strb.half ? reqAddr[2:1] : reqAddr[3:2]);
      end else if (strb.step) begin
        idx <= idx + 1'b1;
      end
      if (strb.capture)
        rdataQ <= halfQ ? DATA_W'(memDin[HALF_W-1:0]) : memDin;
    end
  end

  always_comb begin
    memAddr = halfQ ? {addrQ[ADDR_W-1:3], idx, addrQ[0]}
                    : {addrQ[ADDR_W-1:4], idx, addrQ[1:0]};
    memDout = wdataQ;
    memDoe  = strb.drive;
    rdata   = rdataQ;
  end

  // R7
  write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.drive && $past(strb.drive)) |-> ($stable(memAddr) && $stable(memDout)));

endmodule

// File: rtl/nor_timing_seq.sv
module nor_timing_seq
  import fts_pkg::*;
#(
  parameter int ADDR_W      = 26,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [((NUM_REGIONS/2 > 1) ? $clog2(NUM_REGIONS/2) : 1)-1:0] cfgIdx,
  input  logic [2*TM_W-1:0]      cfgData,
  input  logic                   req,
  input  logic                   reqWe,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic [DATA_W-1:0]      rdata,
  output logic                   done,
  input  logic                   refReq,
  output logic                   refGnt,
  output logic [NUM_REGIONS-1:0] memCsN,
  output logic                   memOeN,
  output logic                   memWeN,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoe,
  input  logic [DATA_W-1:0]      memDin
);

  localparam int RSEL_W = $clog2(NUM_REGIONS);

  strobe_t strb;

  fts_ctrl #(.NUM_REGIONS(NUM_REGIONS)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .req(req), .reqWe(reqWe), .reqRegion(reqAddr[ADDR_W-1 -: RSEL_W]),
    .refReq(refReq), .strb(strb), .memCsN(memCsN), .memOeN(memOeN),
    .memWeN(memWeN), .done(done), .refGnt(refGnt)
  );

  fts_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDin(memDin), .memAddr(memAddr), .memDout(memDout), .memDoe(memDoe),
    .rdata(rdata)
  );

endmodule

// File: tb/nor_timing_seq_bench.sv
module nor_timing_seq_bench;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe, cfgIdx, req, reqWe, refReq;
  logic [31:0] cfgData, reqWdata, rdata, memDout, memDin;
  logic [25:0] reqAddr, memAddr;
  logic        done, refGnt, memOeN, memWeN, memDoe;
  logic [3:0]  memCsN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [31:0] model(input logic [25:0] a);
    return {a[15:0], 6'd0, a[25:16]} ^ 32'h5A5A_3C3C;
  endfunction

  assign memDin = model(memAddr);

  nor_timing_seq u_nor_timing_seq (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgData(cfgData),
    .req(req), .reqWe(reqWe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdata(rdata), .done(done), .refReq(refReq), .refGnt(refGnt),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memAddr(memAddr),
    .memDout(memDout), .memDoe(memDoe), .memDin(memDin)
  );

  logic [3:0]  hCs   [0:63];
  logic        hOe   [0:63];
  logic        hWe   [0:63];
  logic        hGnt  [0:63];
  logic        hDoe  [0:63];
  logic        hDone [0:63];
  logic [25:0] hAddr [0:63];
  logic [31:0] hDout [0:63];
  int          doneIdx [0:7];
  logic [31:0] doneVal [0:7];
  int          nDone;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic idx, input logic [31:0] d);
    @(negedge clk); cfgWe = 1'b1; cfgIdx = idx; cfgData = d;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  // Cycle k is the k-th cycle after the edge that samples the request
  task automatic runSeq(input logic we, input logic [25:0] a, input logic [31:0] wd,
                        input int refOn, input int refOff, input int exK,
                        input logic exWe, input int nCyc);
    @(negedge clk);
    req = 1'b1; reqWe = we; reqAddr = a; reqWdata = wd;
    refReq = (refOn <= 0) && (refOff > 0);
    nDone = 0;
    for (int k = 1; k <= nCyc; k++) begin
      @(negedge clk);
      hCs[k] = memCsN; hOe[k] = memOeN; hWe[k] = memWeN; hGnt[k] = refGnt;
      hDoe[k] = memDoe; hDone[k] = done; hAddr[k] = memAddr; hDout[k] = memDout;
      if (done) begin
        if (nDone < 8) begin doneIdx[nDone] = k; doneVal[nDone] = rdata; end
        nDone++;
      end
      req = (k == exK);
      if (k == exK) reqWe = exWe;
      refReq = (k >= refOn) && (k < refOff);
    end
    req = 1'b0; refReq = 1'b0;
  endtask

  function automatic int csLowCount(input int r, input int n);
    int c = 0;
    for (int k = 1; k <= n; k++) if (!hCs[k][r]) c++;
    return c;
  endfunction

  function automatic int lowCount(input bit useWe, input int n);
    int c = 0;
    for (int k = 1; k <= n; k++) if (useWe ? !hWe[k] : !hOe[k]) c++;
    return c;
  endfunction

  task automatic tReset();
    chk(memCsN == 4'hF && memOeN && memWeN && !done && !refGnt, "R1 idle pins",
        {memCsN, memOeN, memWeN, done, refGnt}, 8'hFC);
    runSeq(1'b0, 26'h2000048, 32'h0, 0, 0, 0, 1'b0, 40);
    chk(nDone == 1 && doneIdx[0] == 33, "R1 default first delay", doneIdx[0], 33);
    chk(csLowCount(2, 40) == 32, "R1 default cs low", csLowCount(2, 40), 32);
    chk(doneVal[0] == model(26'h2000048), "R3 default read data", doneVal[0], model(26'h2000048));
  endtask

  task automatic tSingle();
    runSeq(1'b0, 26'h1000014, 32'h0, 0, 0, 0, 1'b0, 10);
    chk(nDone == 1 && doneIdx[0] == 4, "R2 region1 high half", doneIdx[0], 4);
    chk(csLowCount(1, 10) == 3 && lowCount(1'b0, 10) == 3, "R3 window F+1", csLowCount(1, 10), 3);
    chk(doneVal[0] == model(26'h1000014), "R5 single address", doneVal[0], model(26'h1000014));
    runSeq(1'b0, 26'h200004C, 32'h0, 0, 0, 0, 1'b0, 12);
    chk(nDone == 1 && doneIdx[0] == 8, "R2 region2 low half", doneIdx[0], 8);
    chk(doneVal[0] == model(26'h200004C), "R5 non-burst data", doneVal[0], model(26'h200004C));
  endtask

  task automatic tBurst32();
    runSeq(1'b0, 26'h0001238, 32'h0, 0, 0, 7, 1'b0, 30);
    chk(nDone == 4, "R12 busy request dropped", nDone, 4);
    for (int i = 0; i < 4; i++) begin
      chk(doneIdx[i] == 6 + 2 * i, "R4 page word timing", doneIdx[i], 6 + 2 * i);
      chk(doneVal[i] == model(26'h0001230 + 26'(4 * i)), "R4 page order",
          doneVal[i], model(26'h0001230 + 26'(4 * i)));
    end
    chk(csLowCount(0, 30) == 11 && hCs[12][0] && lowCount(1'b0, 30) == 11,
        "R4 continuous select", csLowCount(0, 30), 11);
    chk(!hDone[7], "R13 single-cycle done", hDone[7], 0);
    chk(lowCount(1'b1, 30) == 0, "R12 no write started", lowCount(1'b1, 30), 0);
  endtask

  task automatic tBurst16();
    runSeq(1'b0, 26'h3000456, 32'h0, 0, 0, 0, 1'b0, 25);
    chk(hAddr[1] == 26'h3000450, "R6 half-bus page base", hAddr[1], 26'h3000450);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] e;
      e = {16'h0, model(26'h3000450 + 26'(2 * i))[15:0]};
      chk(doneIdx[i] == 5 + 3 * i, "R6 half-bus timing", doneIdx[i], 5 + 3 * i);
      chk(doneVal[i] == e, "R6 half-bus data", doneVal[i], e);
    end
  endtask

  task automatic tWrite();
    runSeq(1'b1, 26'h1000020, 32'hCAFEF00D, 0, 0, 11, 1'b1, 25);
    chk(!hCs[1][1] && hWe[1] && hDoe[1], "R7 select before write", {hCs[1][1], hWe[1], hDoe[1]}, 3'b011);
    chk(lowCount(1'b1, 25) == 4 && !hWe[2] && !hWe[5], "R7 write pulse P+1", lowCount(1'b1, 25), 4);
    chk(!hCs[6][1] && hWe[6] && hDoe[6] && hDout[6] == 32'hCAFEF00D && hAddr[6] == 26'h1000020,
        "R7 hold after write", hDout[6], 32'hCAFEF00D);
    chk(lowCount(1'b0, 25) == 0, "R7 output enable idle", lowCount(1'b0, 25), 0);
    chk(nDone == 1 && doneIdx[0] == 7, "R13 write done", doneIdx[0], 7);
    chk(csLowCount(1, 25) == 6, "R8 request in recovery dropped", csLowCount(1, 25), 6);
    runSeq(1'b1, 26'h1000020, 32'h12345678, 0, 0, 12, 1'b0, 25);
    chk(hCs[12][1] && !hCs[13][1], "R8 accepted after 2C+1", {hCs[12][1], hCs[13][1]}, 2'b10);
    chk(nDone == 2 && doneIdx[1] == 16 && doneVal[1] == model(26'h1000020),
        "R8 read after recovery", doneIdx[1], 16);
  endtask

  task automatic tRefresh();
    runSeq(1'b0, 26'h0000100, 32'h0, 3, 8, 0, 1'b0, 30);
    chk(!hCs[4][0] && !hGnt[4], "R9 no grant mid-word", {hCs[4][0], hGnt[4]}, 0);
    chk(hGnt[6] && hCs[6] == 4'hF && hOe[6], "R9 grant releases bus", {hGnt[6], hCs[6]}, 5'h1F);
    chk(hGnt[8] && !hGnt[9] && !hCs[9][0], "R9 grant held until drop", {hGnt[8], hGnt[9]}, 2'b10);
    chk(nDone == 4 && doneIdx[1] == 14, "R10 first delay after refresh", doneIdx[1], 14);
    chk(doneIdx[2] == 16 && doneIdx[3] == 18, "R10 page delay resumes", doneIdx[3], 18);
    for (int i = 0; i < 4; i++)
      chk(doneVal[i] == model(26'h0000100 + 26'(4 * i)), "R10 data across refresh",
          doneVal[i], model(26'h0000100 + 26'(4 * i)));
  endtask

  task automatic tIdleRef();
    runSeq(1'b0, 26'h1000000, 32'h0, 0, 3, 0, 1'b0, 15);
    chk(hGnt[1] && hCs[1] == 4'hF, "R11 idle grant", {hGnt[1], hCs[1]}, 5'h1F);
    chk(hGnt[3] && !hGnt[4], "R11 grant length", {hGnt[3], hGnt[4]}, 2'b10);
    chk(nDone == 0 && csLowCount(1, 15) == 0, "R11 request dropped", nDone, 0);
  endtask

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgIdx = 1'b0; cfgData = '0;
    req = 1'b0; reqWe = 1'b0; reqAddr = '0; reqWdata = '0; refReq = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    cfgWrite(1'b0, {16'h4310, 16'h2122});
    cfgWrite(1'b1, {16'h021E, 16'h0031});
    tSingle();
    tBurst32();
    tBurst16();
    tWrite();
    tRefresh();
    tIdleRef();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule